// File: doc/BRIEF.md
# PCI Bus-Master DMA Engine

This block lets a PCI target device also act as a bus master. It moves a burst of 32-bit words between the device's own local memory and a memory range on another PCI target. Three registers hold the transfer setup: a PCI byte address, a local word address and a control word. The target logic around the block writes them when it decodes PCI target writes. No local processor port can reach them.

Writing the control word with its start bit set and a non-zero count begins the transfer. The engine requests the bus and waits until it is granted and the bus is idle. It then drives one memory-command address phase and keeps FRAME asserted through the burst. FRAME is dropped on the final data phase, so the burst moves exactly the programmed number of words.

The engine counts only the data phases that complete. On the last one it clears the start bit, sets a sticky done flag and releases its request. It then drives FRAME and IRDY high for one turnaround cycle and lets go of the bus pins. Bus pins are modelled as separate value and output-enable signals. Every active-low signal is low when asserted.

Top module: `pci_dma_master`

## Requirements
- R1: After reset, req_no and frame_no are 1, frame_oe_o, irdy_oe_o, ad_oe_o and cbe_oe_o are 0, and done_o is 0.
- R2: Registers are written when reg_we_i is 1 and are selected by reg_sel_i. Select 0 is the PCI byte address, whose bits [1:0] are forced to 0. Select 1 is the local word address. Select 2 is the control word: bits [COUNT_W-1:0] hold the word count, bit 30 the direction (1 = local to PCI), bit 31 the start bit. A control write with start 1 and a non-zero count starts a transfer. A control write with a zero count is ignored completely: it neither starts a transfer nor clears done_o.
- R3: Once started, req_no goes low. The address phase, in which FRAME is driven low, begins only on the clock after a rising edge that sampled gnt_ni low with frame_ni and irdy_ni both high.
- R4: During the address phase, ad_o carries the PCI address with ad_oe_o at 1 and irdy_no driven high. cbe_o is 0111 (memory write) when the direction is local to PCI, and 0110 (memory read) when it is PCI to local. No other command is ever issued.
- R5: During data phases, irdy_no is driven low and cbe_o is 0000. A phase completes only on an edge where trdy_ni is low. When the direction is local to PCI, ad_o drives lm_rdata_i with ad_oe_o at 1. When it is PCI to local, ad_oe_o is 0 and lm_we_o is 1 on the completing edge, with lm_wdata_o equal to ad_i.
- R6: Each completed phase advances the PCI address by 4 and the local address by 1; no other cycle moves them. The pointers keep their values after a burst, so a control-only start continues from where the last burst ended.
- R7: frame_no is 1 exactly during the final data phase, and a burst completes exactly the programmed count of phases.
- R8: On the final completed phase, done_o becomes 1 and stays 1 until the next accepted start. The next cycle is a turnaround in which frame_no and irdy_no are driven 1 with their enables at 1. After that, every bus enable is 0 and req_no is 1.
- R9: While a transfer is in progress, register writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe from target decode |
| reg_sel_i | input | 2 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| done_o | output | 1 | Sticky transfer-done flag |
| req_no | output | 1 | Bus request, active low |
| gnt_ni | input | 1 | Bus grant, active low |
| frame_ni | input | 1 | Sampled bus FRAME |
| irdy_ni | input | 1 | Sampled bus IRDY |
| trdy_ni | input | 1 | Target ready, active low |
| frame_no | output | 1 | FRAME value driven |
| frame_oe_o | output | 1 | FRAME output enable |
| irdy_no | output | 1 | IRDY value driven |
| irdy_oe_o | output | 1 | IRDY output enable |
| ad_i | input | 32 | Sampled address/data bus |
| ad_o | output | 32 | Address/data value driven |
| ad_oe_o | output | 1 | Address/data output enable |
| cbe_o | output | 4 | Command / byte-enable value driven |
| cbe_oe_o | output | 1 | Command / byte-enable output enable |
| lm_addr_o | output | LADDR_W | Local memory word address |
| lm_we_o | output | 1 | Local memory write enable |
| lm_wdata_o | output | 32 | Local memory write data |
| lm_rdata_i | input | 32 | Local memory read data (combinational) |

## Verification
The bench builds the engine with COUNT_W = 5 and LADDR_W = 6. The largest count, 31 words, therefore fits in one short burst. The local pointer's range also matches a 64-word local memory model, and PCI bursts are kept inside a 256-byte window. With these sizes the bench runs a maximum-length burst, a single-word burst, a zero-count start and a burst that continues from the previous pointers. It also runs target wait patterns that are zero-wait, alternate-cycle and every third cycle, in both directions, all within a few thousand cycles.

// File: rtl/pci_dma_pkg.sv
package pci_dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_ADDR,
    ST_DATA,
    ST_TURN
  } dma_state_e;

  localparam logic [1:0] SEL_PCI_ADDR = 2'd0;
  localparam logic [1:0] SEL_LOC_ADDR = 2'd1;
  localparam logic [1:0] SEL_CTRL     = 2'd2;

  localparam int CTRL_START_BIT = 31;
  localparam int CTRL_DIR_BIT   = 30;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
  localparam logic [3:0] CBE_ALL_ON = 4'b0000;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import pci_dma_pkg::*;
#(
  parameter int COUNT_W = 16,
  parameter int LADDR_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [1:0]         reg_sel_i,
  input  logic [31:0]        reg_wdata_i,
  input  logic               xfer_i,
  output logic [31:0]        pci_addr_o,
  output logic [LADDR_W-1:0] loc_addr_o,
  output logic               dir_wr_o,
  output logic               start_o,
  output logic               last_o,
  output logic               done_o
);
  localparam logic [COUNT_W-1:0] CNT_ONE = COUNT_W'(1);

  logic [31:0]        pci_addr_q;
  logic [LADDR_W-1:0] loc_addr_q;
  logic [COUNT_W-1:0] cnt_q;
  logic               dir_q, start_q, done_q;
  logic [COUNT_W-1:0] wr_cnt;
  logic               unused_wdata;

  assign wr_cnt       = reg_wdata_i[COUNT_W-1:0];
  assign unused_wdata = ^reg_wdata_i[CTRL_DIR_BIT-1:COUNT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pci_addr_q <= '0;
      loc_addr_q <= '0;
      cnt_q      <= '0;
      dir_q      <= 1'b0;
      start_q    <= 1'b0;
      done_q     <= 1'b0;
    end else if (start_q) begin
      if (xfer_i) begin
        pci_addr_q <= pci_addr_q + 32'd4;
        loc_addr_q <= loc_addr_q + 1'b1;
        cnt_q      <= cnt_q - 1'b1;
        if (cnt_q == CNT_ONE) begin
          start_q <= 1'b0;
          done_q  <= 1'b1;
        end
      end
    end else if (reg_we_i) begin
      unique case (reg_sel_i)
        SEL_PCI_ADDR: pci_addr_q <= {reg_wdata_i[31:2], 2'b00};
        SEL_LOC_ADDR: loc_addr_q <= reg_wdata_i[LADDR_W-1:0];
        SEL_CTRL: if (wr_cnt != '0) begin
          cnt_q   <= wr_cnt;
          dir_q   <= reg_wdata_i[CTRL_DIR_BIT];
          start_q <= reg_wdata_i[CTRL_START_BIT];
          if (reg_wdata_i[CTRL_START_BIT]) done_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign pci_addr_o = pci_addr_q;
  assign loc_addr_o = loc_addr_q;
  assign dir_wr_o   = dir_q;
  assign start_o    = start_q;
  assign last_o     = (cnt_q == CNT_ONE);
  assign done_o     = done_q;

  // R9
  busy_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_q && reg_we_i && !xfer_i) |=> (loc_addr_q == $past(loc_addr_q) && dir_q == $past(dir_q)));
  // R7
  count_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |-> (cnt_q != '0));
  // R8
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_q) |-> start_q);
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import pci_dma_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       last_i,
  input  logic       gnt_ni,
  input  logic       frame_ni,
  input  logic       irdy_ni,
  input  logic       trdy_ni,
  output dma_state_e state_o,
  output logic       xfer_o
);
  dma_state_e state_q, state_d;
  logic       bus_free;

  assign bus_free = !gnt_ni && frame_ni && irdy_ni;
  assign xfer_o   = (state_q == ST_DATA) && !trdy_ni;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_REQ;
      ST_REQ:  if (bus_free) state_d = ST_ADDR;
      ST_ADDR: state_d = ST_DATA;
      ST_DATA: if (xfer_o && last_i) state_d = ST_TURN;
      ST_TURN: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // R8
  turn_after_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TURN) |-> ($past(state_q) == ST_DATA));
  // R5
  data_needs_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA) |-> start_i);
endmodule

// File: rtl/dma_pins.sv
module dma_pins
  import pci_dma_pkg::*;
(
  input  dma_state_e  state_i,
  input  logic        dir_wr_i,
  input  logic        last_i,
  input  logic [31:0] pci_addr_i,
  input  logic [31:0] lm_rdata_i,
  output logic        req_no,
  output logic        frame_no,
  output logic        frame_oe_o,
  output logic        irdy_no,
  output logic        irdy_oe_o,
  output logic [31:0] ad_o,
  output logic        ad_oe_o,
  output logic [3:0]  cbe_o,
  output logic        cbe_oe_o
);
  always_comb begin
    req_no     = 1'b1;
    frame_no   = 1'b1;
    frame_oe_o = 1'b0;
    irdy_no    = 1'b1;
    irdy_oe_o  = 1'b0;
    ad_o       = '0;
    ad_oe_o    = 1'b0;
    cbe_o      = CBE_ALL_ON;
    cbe_oe_o   = 1'b0;
    unique case (state_i)
      ST_REQ: req_no = 1'b0;
      ST_ADDR: begin
        req_no     = 1'b0;
        frame_no   = 1'b0;
        frame_oe_o = 1'b1;
        irdy_oe_o  = 1'b1;
        ad_o       = pci_addr_i;
        ad_oe_o    = 1'b1;
        cbe_o      = dir_wr_i ? CMD_MEM_WR : CMD_MEM_RD;
        cbe_oe_o   = 1'b1;
      end
      ST_DATA: begin
        req_no     = 1'b0;
        frame_no   = last_i;
        frame_oe_o = 1'b1;
        irdy_no    = 1'b0;
        irdy_oe_o  = 1'b1;
        ad_o       = dir_wr_i ? lm_rdata_i : '0;
        ad_oe_o    = dir_wr_i;
        cbe_oe_o   = 1'b1;
      end
      ST_TURN: begin
        frame_oe_o = 1'b1;
        irdy_oe_o  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pci_dma_master.sv
module pci_dma_master
  import pci_dma_pkg::*;
#(
  parameter int COUNT_W = 16,
  parameter int LADDR_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [1:0]         reg_sel_i,
  input  logic [31:0]        reg_wdata_i,
  output logic               done_o,
  output logic               req_no,
  input  logic               gnt_ni,
  input  logic               frame_ni,
  input  logic               irdy_ni,
  input  logic               trdy_ni,
  output logic               frame_no,
  output logic               frame_oe_o,
  output logic               irdy_no,
  output logic               irdy_oe_o,
  input  logic [31:0]        ad_i,
  output logic [31:0]        ad_o,
  output logic               ad_oe_o,
  output logic [3:0]         cbe_o,
  output logic               cbe_oe_o,
  output logic [LADDR_W-1:0] lm_addr_o,
  output logic               lm_we_o,
  output logic [31:0]        lm_wdata_o,
  input  logic [31:0]        lm_rdata_i
);
  dma_state_e         state;
  logic [31:0]        pci_addr;
  logic [LADDR_W-1:0] loc_addr;
  logic               dir_wr, start, last, xfer;

  dma_regs #(.COUNT_W(COUNT_W), .LADDR_W(LADDR_W)) i_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_sel_i, .reg_wdata_i,
    .xfer_i(xfer), .pci_addr_o(pci_addr), .loc_addr_o(loc_addr),
    .dir_wr_o(dir_wr), .start_o(start), .last_o(last), .done_o
  );

  dma_seq i_seq (
    .clk_i, .rst_ni, .start_i(start), .last_i(last), .gnt_ni, .frame_ni,
    .irdy_ni, .trdy_ni, .state_o(state), .xfer_o(xfer)
  );

  dma_pins i_pins (
    .state_i(state), .dir_wr_i(dir_wr), .last_i(last), .pci_addr_i(pci_addr),
    .lm_rdata_i, .req_no, .frame_no, .frame_oe_o, .irdy_no, .irdy_oe_o,
    .ad_o, .ad_oe_o, .cbe_o, .cbe_oe_o
  );

  assign lm_addr_o  = loc_addr;
  assign lm_we_o    = xfer && !dir_wr;
  assign lm_wdata_o = ad_i;

  // R3
  addr_phase_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(frame_no) |-> $past(!gnt_ni && frame_ni && irdy_ni));
  // R4
  addr_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_oe_o && !frame_no && irdy_no) |-> (cbe_o == CMD_MEM_RD || cbe_o == CMD_MEM_WR));
  // R7
  last_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irdy_no && frame_no && !trdy_ni) |=> irdy_no);
  // R8
  done_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(!irdy_no && frame_no && !trdy_ni));
  // R5
  lm_write_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lm_we_o |-> (!ad_oe_o && !irdy_no));
endmodule

// File: tb/test_pci_dma_master.sv
`timescale 1ns/1ps
module test_pci_dma_master;
  localparam int COUNT_W = 5;
  localparam int LADDR_W = 6;

  typedef struct packed {
    logic [31:0]        data;
    logic [LADDR_W-1:0] laddr;
    logic               last;
    logic               wr;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic done, req_n, gnt_n, frame_n_in, irdy_n_in, trdy_n = 1'b1;
  logic frame_n, frame_oe, irdy_n, irdy_oe, ad_oe, cbe_oe, lm_we;
  logic [31:0] ad_in = '0, ad_out, lm_wdata, lm_rdata;
  logic [3:0] cbe;
  logic [LADDR_W-1:0] lm_addr;
  logic hold_gnt = 1'b0, ext_frame_n = 1'b1;

  logic [31:0] lmem [64];
  logic [31:0] pmem [64];
  item_t sb_q[$];
  logic [3:0]  exp_cmd;
  logic [31:0] exp_addr, cur_addr;
  logic [31:0] m_pci;
  logic [LADDR_W-1:0] m_loc;
  int checks = 0, failures = 0, wait_mode = 0, wait_ctr = 0;
  bit in_burst = 1'b0, finished = 1'b0;

  always #4 clk = ~clk;

  assign gnt_n      = hold_gnt ? 1'b1 : req_n;
  assign frame_n_in = (frame_oe ? frame_n : 1'b1) & ext_frame_n;
  assign irdy_n_in  = irdy_oe ? irdy_n : 1'b1;
  assign lm_rdata   = lmem[lm_addr];

  pci_dma_master #(.COUNT_W(COUNT_W), .LADDR_W(LADDR_W)) i_pci_dma_master (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .done_o(done), .req_no(req_n), .gnt_ni(gnt_n),
    .frame_ni(frame_n_in), .irdy_ni(irdy_n_in), .trdy_ni(trdy_n),
    .frame_no(frame_n), .frame_oe_o(frame_oe), .irdy_no(irdy_n), .irdy_oe_o(irdy_oe),
    .ad_i(ad_in), .ad_o(ad_out), .ad_oe_o(ad_oe), .cbe_o(cbe), .cbe_oe_o(cbe_oe),
    .lm_addr_o(lm_addr), .lm_we_o(lm_we), .lm_wdata_o(lm_wdata), .lm_rdata_i(lm_rdata)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) if (lm_we) lmem[lm_addr] <= lm_wdata;

  // monitor: target model and scoreboard consumer
  initial begin
    item_t it;
    bit go;
    forever begin
      @(negedge clk);
      if (frame_oe && !frame_n && irdy_n) begin
        check(cbe == exp_cmd && cbe_oe, "R4", "address phase command", {28'd0, cbe}, {28'd0, exp_cmd});
        check(ad_out == exp_addr && ad_oe, "R4", "address phase address", ad_out, exp_addr);
        cur_addr = ad_out;
        in_burst = 1'b1;
        wait_ctr = 0;
      end
      go = 1'b0;
      if (in_burst && !irdy_n) begin
        wait_ctr++;
        case (wait_mode)
          1: go = (wait_ctr % 2 == 0);
          2: go = (wait_ctr % 3 == 0);
          default: go = 1'b1;
        endcase
      end
      trdy_n = !go;
      ad_in  = pmem[cur_addr[7:2]];
      #1;
      if (go) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R7", "data phase beyond count", 32'd1, 32'd0);
        end else begin
          it = sb_q.pop_front();
          check(cbe == 4'b0000 && cbe_oe, "R5", "data phase byte enables", {28'd0, cbe}, 32'd0);
          check(frame_n == it.last, "R7", "frame on data phase", {31'd0, frame_n}, {31'd0, it.last});
          check(lm_addr == it.laddr, "R6", "local pointer", {26'd0, lm_addr}, {26'd0, it.laddr});
          if (it.wr) begin
            check(ad_oe && ad_out == it.data, "R5", "write data on bus", ad_out, it.data);
            check(!lm_we, "R5", "no local write in write direction", {31'd0, lm_we}, 32'd0);
            pmem[cur_addr[7:2]] = ad_out;
          end else begin
            check(lm_we && lm_wdata == it.data && !ad_oe, "R5", "read data to local",
                  lm_wdata, it.data);
          end
        end
        cur_addr = cur_addr + 32'd4;
        if (frame_n) in_burst = 1'b0;
      end
    end
  end

  task automatic reg_write(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // driver: program registers and push expected items
  task automatic start_dma(input logic [31:0] pci, input logic [LADDR_W-1:0] loc,
                           input int cnt, input bit wr, input int mode, input bit full);
    item_t it;
    if (full) begin
      m_pci = {pci[31:2], 2'b00};
      m_loc = loc;
      reg_write(2'd0, pci);
      reg_write(2'd1, {26'd0, loc});
    end
    wait_mode = mode;
    exp_cmd   = wr ? 4'b0111 : 4'b0110;
    exp_addr  = m_pci;
    for (int i = 0; i < cnt; i++) begin
      it.wr    = wr;
      it.last  = (i == cnt - 1);
      it.laddr = m_loc;
      it.data  = wr ? lmem[m_loc] : pmem[m_pci[7:2]];
      sb_q.push_back(it);
      m_pci = m_pci + 32'd4;
      m_loc = m_loc + 1'b1;
    end
    reg_write(2'd2, {1'b1, wr, 25'd0, cnt[COUNT_W-1:0]});
  endtask

  task automatic finish_dma(input string tag);
    int n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    check(done, "R8", {tag, " done raised"}, {31'd0, done}, 32'd1);
    check(sb_q.size() == 0, "R7", {tag, " all phases completed"}, sb_q.size(), 32'd0);
    check(frame_oe && frame_n && irdy_oe && irdy_n, "R8", {tag, " turnaround drive"},
          {28'd0, frame_oe, frame_n, irdy_oe, irdy_n}, 32'hF);
    @(negedge clk);
    check(!frame_oe && !irdy_oe && !ad_oe && !cbe_oe && req_n, "R8", {tag, " bus released"},
          {27'd0, frame_oe, irdy_oe, ad_oe, cbe_oe, req_n}, 32'h1);
    repeat (3) @(negedge clk);
    check(done && req_n, "R8", {tag, " done sticky"}, {30'd0, done, req_n}, 32'h3);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      lmem[i] = 32'hA000_0000 + i * 32'h0001_0101;
      pmem[i] = 32'h5A00_0000 ^ (i * 32'h0013_0007);
    end
    repeat (3) @(negedge clk);
    check(req_n && frame_n && !frame_oe && !irdy_oe && !ad_oe && !cbe_oe && !done, "R1",
          "reset state", {25'd0, req_n, frame_n, frame_oe, irdy_oe, ad_oe, cbe_oe, done}, 32'h60);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(req_n && !frame_oe, "R1", "idle after reset", {30'd0, req_n, frame_oe}, 32'h2);

    // T1: local to PCI, zero wait
    start_dma(32'h0000_0040, 6'd2, 5, 1'b1, 0, 1'b1);
    finish_dma("T1 R2");
    check(pmem[16] == lmem[2] && pmem[20] == lmem[6], "R5", "PCI memory after write burst",
          pmem[20], lmem[6]);

    // T2: PCI to local, alternate waits
    start_dma(32'h0000_0012, 6'd20, 4, 1'b0, 1, 1'b1);
    finish_dma("T2");
    // T3: continue from advanced pointers, every third cycle ready
    start_dma(32'h0, 6'd0, 3, 1'b0, 2, 1'b0);
    finish_dma("T3 R6");
    check(lmem[26] == pmem[10], "R6", "continued burst landed", lmem[26], pmem[10]);

    // T4: arbitration wait and writes while busy
    hold_gnt = 1'b1;
    start_dma(32'h0000_00C0, 6'd40, 1, 1'b1, 0, 1'b1);
    repeat (4) @(negedge clk);
    check(!req_n && !frame_oe, "R3", "request without grant", {30'd0, req_n, frame_oe}, 32'h0);
    reg_write(2'd0, 32'h0000_0004);
    reg_write(2'd1, 32'd9);
    reg_write(2'd2, 32'h8000_0007);
    ext_frame_n = 1'b0;
    hold_gnt    = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check(!frame_oe, "R3", "no address phase while bus busy", {31'd0, frame_oe}, 32'd0);
    end
    ext_frame_n = 1'b1;
    finish_dma("T4 R9");

    // T5: zero count ignored
    reg_write(2'd2, 32'hC000_0000);
    repeat (4) @(negedge clk);
    check(req_n && done && !frame_oe, "R2", "zero count ignored", {30'd0, req_n, done}, 32'h3);

    // T6: maximum count
    start_dma(32'h0000_0080, 6'd30, 31, 1'b1, 1, 1'b1);
    finish_dma("T6");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule